// File: doc/BRIEF.md
# Character Display Entry-Mode and Visibility Unit

This unit sits beside the data path of a character display controller. It recognises two instructions on the host bus and keeps the state they govern. The first sets the direction of travel and whether the whole screen scrolls. The second switches the screen, the cursor and the blink on or off. It also tracks the RAM address counter, the cursor column and the screen shift offset. These move on every character, glyph or attribute access that the surrounding controller reports through a one-cycle access pulse.

Each accepted instruction opens a busy window of a fixed number of clock cycles. Instruction writes that arrive during the window are dropped. RAM accesses carry on during the window and use whatever entry mode is in force when they occur.

Top module: `lcd_entry_disp_ctl`

## Requirements
- R1: An instruction write takes effect only in a cycle where `wr_stb`=1, `rs1`=1, `rs0`=0 and `rw`=0. Any other combination changes no state and does not raise busy.
- R2: A data byte whose bits 7..2 are 000001 sets the entry mode, with bit 1 the direction flag (1 = increment) and bit 0 the scroll flag. A byte that matches neither this pattern nor the visibility pattern is ignored and does not raise busy.
- R3: Every access pulse moves the address counter by +1 when the direction flag is 1 and by -1 when it is 0, wrapping modulo 128 (0 - 1 = 127).
- R4: With the scroll flag at 0, every access leaves the shift offset unchanged and moves the cursor by the same step as the address counter, modulo 128.
- R5: With the scroll flag at 1, a write to display RAM (`acc_tgt`=0, `acc_rd`=0) leaves the cursor unchanged. It moves the shift offset by +1 (screen moves left) when the direction flag is 1 and by -1 when it is 0, wrapping modulo LINE_LEN=40 (0 - 1 = 39, 39 + 1 = 0).
- R6: With the scroll flag at 1, a display RAM read, or any access with `acc_tgt` other than 0 (1 = glyph RAM, 2 = attribute RAM), leaves the offset unchanged and moves the cursor as in R4.
- R7: A data byte whose bits 7..3 are 00001 sets the visibility state from bit 2 (screen), bit 1 (cursor) and bit 0 (blink). The outputs are `disp_on` = bit 2, `cursor_on` = bit 1 AND bit 2, and `blink_on` = bit 0 AND bit 2.
- R8: `busy` is 1 from the cycle after an accepted instruction and stays 1 for exactly BUSY_CYC=10 cycles.
- R9: An instruction write that arrives while `busy` is 1 is ignored.
- R10: An access in the same cycle as an accepted entry-mode write uses the entry mode that was in force before that write.
- R11: After reset the direction flag is 1, the scroll flag is 0, all visibility flags are 0, and the address, cursor, offset and busy are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Host bus write strobe, one cycle |
| rs1 | input | 1 | Register select, upper bit |
| rs0 | input | 1 | Register select, lower bit |
| rw | input | 1 | 1 = read cycle, 0 = write cycle |
| data | input | 8 | Host data byte |
| acc_vld | input | 1 | One-cycle pulse: a RAM byte was accessed |
| acc_tgt | input | 2 | Accessed RAM: 0 display, 1 glyph, 2 attribute |
| acc_rd | input | 1 | 1 = the access was a read |
| addr | output | 7 | Address counter |
| cursor | output | 7 | Cursor column |
| shift_ofs | output | 6 | Screen shift offset |
| disp_on | output | 1 | Screen visible |
| cursor_on | output | 1 | Cursor visible |
| blink_on | output | 1 | Blink active |
| busy | output | 1 | Instruction window in progress |

## Verification
An entry-mode write and a RAM access can land in the same clock cycle. The access must then step with the mode that existed before the write. The bench drives both on one edge after setting a mode of the opposite direction, and checks that the address moves the old way. A second access after the busy window must then move the new way. The bench also sweeps every pairing of direction and scroll flags against every access target and direction, and compares the three position registers with an arithmetic model.

// File: rtl/lcd_ctl_pkg.sv
package lcd_ctl_pkg;

  typedef enum logic [1:0] {
    TGT_DISP = 2'd0,
    TGT_GLYPH = 2'd1,
    TGT_ATTR = 2'd2,
    TGT_RSVD = 2'd3
  } acc_tgt_e;

  localparam logic [5:0] MODE_PAT = 6'b000001;
  localparam logic [4:0] VIS_PAT = 5'b00001;

endpackage

// File: rtl/lcd_cmd_decode.sv
module lcd_cmd_decode (
  input  logic       wr_stb,
  input  logic       rs1,
  input  logic       rs0,
  input  logic       rw,
  input  logic [7:0] data,
  input  logic       busy,
  output logic       mode_wr,
  output logic       mode_inc,
  output logic       mode_scroll,
  output logic       vis_wr,
  output logic       vis_disp,
  output logic       vis_curs,
  output logic       vis_blink
);
  import lcd_ctl_pkg::*;

  logic cmd_slot;

  always_comb begin
    cmd_slot    = wr_stb && rs1 && !rs0 && !rw && !busy;
    mode_wr     = cmd_slot && (data[7:2] == MODE_PAT);
    vis_wr      = cmd_slot && (data[7:3] == VIS_PAT);
    mode_inc    = data[1];
    mode_scroll = data[0];
    vis_disp    = data[2];
    vis_curs    = data[1] && data[2];
    vis_blink   = data[0] && data[2];
  end

endmodule

// File: rtl/lcd_busy_timer.sv
module lcd_busy_timer #(
  parameter int BUSY_CYC = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(BUSY_CYC + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (start) begin
      remain <= CW'(BUSY_CYC);
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign busy = (remain != '0);

  // R8
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);

  // R8
  busy_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(remain) == CW'(1));

endmodule

// File: rtl/lcd_pos_tracker.sv
module lcd_pos_tracker #(
  parameter int AW       = 7,
  parameter int OW       = 6,
  parameter int LINE_LEN = 40
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          scroll,
  input  logic          acc_vld,
  input  logic [1:0]    acc_tgt,
  input  logic          acc_rd,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] cursor,
  output logic [OW-1:0] ofs
);
  import lcd_ctl_pkg::*;

  localparam logic [OW-1:0] OFS_LAST = OW'(LINE_LEN - 1);

  logic [AW-1:0] step;
  logic          scroll_hit;
  logic [OW-1:0] ofs_next;

  always_comb begin
    step       = inc ? AW'(1) : {AW{1'b1}};
    scroll_hit = scroll && (acc_tgt == TGT_DISP) && !acc_rd;
    if (inc) begin
      ofs_next = (ofs == OFS_LAST) ? '0 : ofs + 1'b1;
    end else begin
      ofs_next = (ofs == '0) ? OFS_LAST : ofs - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr   <= '0;
      cursor <= '0;
      ofs    <= '0;
    end else if (acc_vld) begin
      addr <= addr + step;
      if (scroll_hit) begin
        ofs <= ofs_next;
      end else begin
        cursor <= cursor + step;
      end
    end
  end

  // R5
  scroll_cursor_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_vld && scroll_hit) |=> $stable(cursor));

  // R4
  no_scroll_ofs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_vld && !scroll) |=> $stable(ofs));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_vld |=> ($stable(addr) && $stable(cursor) && $stable(ofs)));

  // R5
  ofs_range_chk: assert property (@(posedge clk) disable iff (rst)
    ofs <= OFS_LAST);

endmodule

// File: rtl/lcd_entry_disp_ctl.sv
module lcd_entry_disp_ctl #(
  parameter int AW       = 7,
  parameter int OW       = 6,
  parameter int LINE_LEN = 40,
  parameter int BUSY_CYC = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_stb,
  input  logic          rs1,
  input  logic          rs0,
  input  logic          rw,
  input  logic [7:0]    data,
  input  logic          acc_vld,
  input  logic [1:0]    acc_tgt,
  input  logic          acc_rd,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] cursor,
  output logic [OW-1:0] shift_ofs,
  output logic          disp_on,
  output logic          cursor_on,
  output logic          blink_on,
  output logic          busy
);

  logic mode_wr, mode_inc, mode_scroll;
  logic vis_wr, vis_disp, vis_curs, vis_blink;
  logic inc_q, scroll_q;

  lcd_cmd_decode u_dec (
    .wr_stb      (wr_stb),
    .rs1         (rs1),
    .rs0         (rs0),
    .rw          (rw),
    .data        (data),
    .busy        (busy),
    .mode_wr     (mode_wr),
    .mode_inc    (mode_inc),
    .mode_scroll (mode_scroll),
    .vis_wr      (vis_wr),
    .vis_disp    (vis_disp),
    .vis_curs    (vis_curs),
    .vis_blink   (vis_blink)
  );

  lcd_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_busy (
    .clk   (clk),
    .rst   (rst),
    .start (mode_wr || vis_wr),
    .busy  (busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      inc_q     <= 1'b1;
      scroll_q  <= 1'b0;
      disp_on   <= 1'b0;
      cursor_on <= 1'b0;
      blink_on  <= 1'b0;
    end else begin
      if (mode_wr) begin
        inc_q    <= mode_inc;
        scroll_q <= mode_scroll;
      end
      if (vis_wr) begin
        disp_on   <= vis_disp;
        cursor_on <= vis_curs;
        blink_on  <= vis_blink;
      end
    end
  end

  lcd_pos_tracker #(.AW(AW), .OW(OW), .LINE_LEN(LINE_LEN)) u_pos (
    .clk     (clk),
    .rst     (rst),
    .inc     (inc_q),
    .scroll  (scroll_q),
    .acc_vld (acc_vld),
    .acc_tgt (acc_tgt),
    .acc_rd  (acc_rd),
    .addr    (addr),
    .cursor  (cursor),
    .ofs     (shift_ofs)
  );

  // R7
  cursor_gate_chk: assert property (@(posedge clk) disable iff (rst)
    cursor_on |-> disp_on);

  // R7
  blink_gate_chk: assert property (@(posedge clk) disable iff (rst)
    blink_on |-> disp_on);

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_stb) |=> ($stable(disp_on) && $stable(cursor_on) && $stable(blink_on) && $stable(inc_q) && $stable(scroll_q)));

  // R1
  non_cmd_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && wr_stb && (rw || rs0 || !rs1)) |=> !busy);

endmodule

// File: tb/tb_lcd_entry_disp_ctl.sv
`timescale 1ns/1ps
module tb_lcd_entry_disp_ctl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_stb = 1'b0, rs1 = 1'b0, rs0 = 1'b0, rw = 1'b0;
  logic [7:0] data = 8'h00;
  logic       acc_vld = 1'b0;
  logic [1:0] acc_tgt = 2'd0;
  logic       acc_rd = 1'b0;
  logic [6:0] addr, cursor;
  logic [5:0] shift_ofs;
  logic       disp_on, cursor_on, blink_on, busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int e_addr = 0, e_cur = 0, e_ofs = 0;
  int e_inc = 1, e_scr = 0;
  int e_d = 0, e_c = 0, e_b = 0;

  always #5 clk = ~clk;

  lcd_entry_disp_ctl dut (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .rs1(rs1), .rs0(rs0), .rw(rw),
    .data(data), .acc_vld(acc_vld), .acc_tgt(acc_tgt), .acc_rd(acc_rd),
    .addr(addr), .cursor(cursor), .shift_ofs(shift_ofs), .disp_on(disp_on),
    .cursor_on(cursor_on), .blink_on(blink_on), .busy(busy)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check({req, " addr"}, int'(addr), e_addr);
    check({req, " cursor"}, int'(cursor), e_cur);
    check({req, " offset"}, int'(shift_ofs), e_ofs);
    check({req, " disp"}, int'(disp_on), e_d);
    check({req, " curs_on"}, int'(cursor_on), e_c);
    check({req, " blink"}, int'(blink_on), e_b);
  endtask

  task automatic model_acc(input int tgt, input int rd);
    int step;
    step = e_inc ? 1 : 127;
    e_addr = (e_addr + step) % 128;
    if (e_scr == 1 && tgt == 0 && rd == 0)
      e_ofs = e_inc ? (e_ofs + 1) % 40 : (e_ofs + 39) % 40;
    else
      e_cur = (e_cur + step) % 128;
  endtask

  task automatic model_cmd(input logic [7:0] d);
    if (d[7:2] == 6'b000001) begin
      e_inc = d[1]; e_scr = d[0];
    end else if (d[7:3] == 5'b00001) begin
      e_d = d[2]; e_c = d[1] & d[2]; e_b = d[0] & d[2];
    end
  endtask

  task automatic bus_wr(input logic r1, input logic r0, input logic w, input logic [7:0] d);
    @(negedge clk);
    rs1 = r1; rs0 = r0; rw = w; data = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic instr(input logic [7:0] d);
    bus_wr(1'b1, 1'b0, 1'b0, d);
    model_cmd(d);
    repeat (10) @(negedge clk);
  endtask

  task automatic access(input int tgt, input int rd);
    @(negedge clk);
    acc_vld = 1'b1; acc_tgt = 2'(tgt); acc_rd = 1'(rd);
    model_acc(tgt, rd);
    @(negedge clk);
    acc_vld = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check_all("R11");
    check("R11 busy", int'(busy), 0);

    // R3 R5 wrap at zero, scroll write with decrement
    instr(8'h05);
    access(0, 0);
    check("R3 addr wrap", int'(addr), 127);
    check("R5 ofs wrap 0-1", int'(shift_ofs), 39);
    check("R5 cursor hold", int'(cursor), 0);
    instr(8'h07);
    access(0, 0);
    check("R5 ofs wrap 39+1", int'(shift_ofs), 0);
    check_all("R5");

    // R3 R4 R5 R6 sweep over modes, targets and directions
    for (int m = 0; m < 4; m++) begin
      instr(8'h04 | 8'(m));
      for (int t = 0; t < 4; t++) begin
        for (int r = 0; r < 2; r++) begin
          for (int k = 0; k < 3; k++) begin
            access(t, r);
            if (e_scr == 0) check_all("R4");
            else if (t == 0 && r == 0) check_all("R5");
            else check_all("R6");
            check("R3 addr", int'(addr), e_addr);
          end
        end
      end
    end

    // R7 all eight visibility codes, and R8 busy window length
    for (int v = 0; v < 8; v++) begin
      bus_wr(1'b1, 1'b0, 1'b0, 8'h08 | 8'(v));
      model_cmd(8'h08 | 8'(v));
      cnt = 0;
      while (busy && cnt < 50) begin
        cnt++;
        @(negedge clk);
      end
      check("R8 busy cycles", cnt, 10);
      check_all("R7");
    end

    // R9 write during busy is dropped
    instr(8'h0F);
    bus_wr(1'b1, 1'b0, 1'b0, 8'h0F);
    bus_wr(1'b1, 1'b0, 1'b0, 8'h08);
    repeat (12) @(negedge clk);
    check_all("R9");
    check("R9 busy", int'(busy), 0);

    // R1 wrong select or read cycle has no effect
    bus_wr(1'b1, 1'b0, 1'b1, 8'h08);
    check("R1 busy rw", int'(busy), 0);
    bus_wr(1'b1, 1'b1, 1'b0, 8'h08);
    check("R1 busy rs0", int'(busy), 0);
    bus_wr(1'b0, 1'b0, 1'b0, 8'h08);
    check("R1 busy rs1", int'(busy), 0);
    check_all("R1");

    // R2 unrelated patterns ignored
    bus_wr(1'b1, 1'b0, 1'b0, 8'h01);
    check("R2 busy 01", int'(busy), 0);
    bus_wr(1'b1, 1'b0, 1'b0, 8'h10);
    check("R2 busy 10", int'(busy), 0);
    bus_wr(1'b1, 1'b0, 1'b0, 8'h80);
    check("R2 busy 80", int'(busy), 0);
    check_all("R2");

    // R10 access in the same cycle as an entry-mode write
    instr(8'h06);
    @(negedge clk);
    rs1 = 1'b1; rs0 = 1'b0; rw = 1'b0; data = 8'h04; wr_stb = 1'b1;
    acc_vld = 1'b1; acc_tgt = 2'd1; acc_rd = 1'b0;
    model_acc(1, 0);
    model_cmd(8'h04);
    @(negedge clk);
    wr_stb = 1'b0; acc_vld = 1'b0;
    check("R10 addr old mode", int'(addr), e_addr);
    check("R10 cursor old mode", int'(cursor), e_cur);
    repeat (10) @(negedge clk);
    access(2, 1);
    check_all("R10 new mode");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule